// File: doc/BRIEF.md
# USB IN Endpoint Short-Packet Scheduler

This block serves the device-to-host direction of a single USB endpoint whose data sits in a circular ring of 16-bit words in shared memory. The local processor fills the ring and owns the write offset. This block owns the read offset. On every IN token it works out how many words lie between the two offsets and picks one of three answers: a full packet, a short packet, or a NAK. When it sends, it fetches words from memory in ring order and streams them out. It moves the published read offset forward only after the host acknowledges the packet.

Short packets are held back on purpose. A 4-bit limit sets how many NAKs the endpoint returns while only a partial packet is waiting. After that many NAKs the partial data goes out. This lets the processor choose how quickly a transfer is closed by a short packet. Token decoding, CRC and data toggle are handled elsewhere. The block sees the token, ACK and timeout only as single-cycle pulses.

Top module: `in_ep_sched`

## Requirements
- R1: After reset the published read offset is 0, and no NAK, memory read or transmit word is issued.
- R2: On an IN token with at least MAXPKT words available, exactly MAXPKT words are streamed. The stream starts at the current read offset and follows ring order. `resp_nak_o` stays low. `tx_last_o` is high on the final word only.
- R3: On an IN token with no words available, `resp_nak_o` pulses for one cycle, in the cycle after the token. The short-packet NAK counter does not advance.
- R4: On an IN token with between 1 and MAXPKT-1 words available, the block answers NAK and advances the counter while the counter is below `nak_limit_i`. Once the counter reaches the limit, it streams all available words as a short packet.
- R5: With `nak_limit_i` = 0, a short packet is sent on the first IN token, with no NAK.
- R6: The read offset changes only on an ACK that follows a sent packet. It then advances by the packet length modulo DEPTH.
- R7: A timeout after a sent packet leaves the read offset unchanged, so the next IN token sends the same words again.
- R8: Offsets run from 0 to DEPTH-1 and wrap to 0. Memory addresses are BASE plus the offset, so a packet that crosses the ring end continues at BASE.
- R9: The short-packet NAK counter returns to zero whenever a packet is sent and whenever the available data reaches MAXPKT.
- R10: IN tokens that arrive while a packet is being streamed or awaiting its handshake produce no NAK and no extra packet. An ACK that arrives while idle leaves the read offset unchanged.
- R11: Memory reads have a one-cycle latency. `tx_valid_o` is high in the cycle after each read, and `tx_data_o` carries the word read back in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr_i | input | $clog2(DEPTH) | Write offset published by the processor |
| nak_limit_i | input | NAKW | Number of NAKs returned before a short packet is released |
| in_token_i | input | 1 | One-cycle pulse for each IN token |
| ack_i | input | 1 | One-cycle pulse when the host acknowledges the packet |
| timeout_i | input | 1 | One-cycle pulse when no handshake arrived |
| rd_ptr_o | output | $clog2(DEPTH) | Published read offset |
| resp_nak_o | output | 1 | One-cycle NAK response |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rdata_i | input | DATA_W | Memory read data, valid one cycle after the strobe |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_data_o | output | DATA_W | Transmit word |
| tx_last_o | output | 1 | Marks the final word of a packet |

## Verification
The bench builds the block with DEPTH = 12, MAXPKT = 4, ADDR_W = 8 and BASE = 0x40. The ring length of 12 is not a power of two, so wrapping only works if the explicit end-of-ring compare works; a plain bit-width rollover would give the wrong offsets. A packet of four words is short enough to drive the ring end into the middle of a packet within a handful of transfers. The 0x40 base shows that addresses are formed as an offset from the ring start, not as a bare offset. Several NAK limits (0, 1 and 3) show where the short packet is released, that empty tokens leave the counter alone, and that the counter clears after a send.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

    // Top-level handshake phase of the endpoint
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for an IN token
        ST_SEND = 2'd1,  // streaming words of the packet
        ST_WAIT = 2'd2   // packet sent, waiting for ACK or timeout
    } ep_state_e;

    // Answer chosen for one IN token
    typedef enum logic [1:0] {
        ANS_NAK_EMPTY = 2'd0,
        ANS_NAK_HOLD  = 2'd1,
        ANS_FULL      = 2'd2,
        ANS_SHORT     = 2'd3
    } ep_answer_e;

    function automatic ep_answer_e pick_answer(input logic empty,
                                               input logic full,
                                               input logic release_ok);
        if (empty)           return ANS_NAK_EMPTY;
        else if (full)       return ANS_FULL;
        else if (release_ok) return ANS_SHORT;
        else                 return ANS_NAK_HOLD;
    endfunction

endpackage

// File: rtl/in_ep_avail.sv
module in_ep_avail #(
    parameter int DEPTH  = 64,
    parameter int MAXPKT = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output logic [CNT_W-1:0] avail_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAXPKT);

    logic [CNT_W-1:0] w_ext;
    logic [CNT_W-1:0] r_ext;

    always_comb begin
        w_ext = {1'b0, wr_ptr_i};
        r_ext = {1'b0, rd_ptr_i};
        if (w_ext >= r_ext) avail_o = w_ext - r_ext;
        else                avail_o = w_ext + DEPTH_C - r_ext;
        empty_o = (avail_o == '0);
        full_o  = (avail_o >= MAX_C);
    end

endmodule

// File: rtl/in_ep_short_ctr.sv
module in_ep_short_ctr #(
    parameter int NAKW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            bump_i,
    input  logic            full_i,
    input  logic [NAKW-1:0] limit_i,
    output logic            release_o
);
    localparam logic [NAKW-1:0] SAT_C = {NAKW{1'b1}};

    typedef struct packed {
        logic [NAKW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clear_i) begin
            ctr_d.cnt = '0;
        end else if (bump_i && ctr_q.cnt != SAT_C) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign release_o = (ctr_q.cnt >= limit_i);

    // R9
    full_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_i |=> (ctr_q.cnt == '0));

    // R4
    hold_only_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bump_i |-> !release_o);

endmodule

// File: rtl/in_ep_word_reader.sv
module in_ep_word_reader #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 16,
    parameter int BASE   = 0,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PTR_W-1:0]  start_off_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              done_o,
    output logic              tx_valid_o,
    output logic              tx_last_o
);
    localparam logic [PTR_W-1:0]  END_C  = PTR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] BASE_C = ADDR_W'(BASE);
    localparam logic [LEN_W-1:0]  ONE_C  = LEN_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] off;
        logic [LEN_W-1:0] remain;
        logic             valid;
        logic             last;
    } rdr_t;

    rdr_t rdr_d, rdr_q;
    logic issue;

    always_comb begin
        rdr_d       = rdr_q;
        rdr_d.valid = 1'b0;
        rdr_d.last  = 1'b0;
        issue       = (rdr_q.remain != '0);
        if (start_i) begin
            rdr_d.off    = start_off_i;
            rdr_d.remain = len_i;
        end else if (issue) begin
            rdr_d.off    = (rdr_q.off == END_C) ? '0 : rdr_q.off + 1'b1;
            rdr_d.remain = rdr_q.remain - 1'b1;
            rdr_d.valid  = 1'b1;
            rdr_d.last   = (rdr_q.remain == ONE_C);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdr_q <= '0;
        else        rdr_q <= rdr_d;
    end

    assign mem_rd_en_o = issue;
    assign mem_addr_o  = BASE_C + ADDR_W'(rdr_q.off);
    assign done_o      = issue && (rdr_q.remain == ONE_C);
    assign tx_valid_o  = rdr_q.valid;
    assign tx_last_o   = rdr_q.last;

    // R8
    addr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (mem_addr_o >= BASE_C) &&
                        (mem_addr_o <= BASE_C + ADDR_W'(DEPTH - 1)));

    // R11
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> tx_valid_o);

    // R2
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);

    // R10
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (rdr_q.remain == '0));

endmodule

// File: rtl/in_ep_sched.sv
module in_ep_sched
    import in_ep_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MAXPKT = 32,
    parameter int ADDR_W = 16,
    parameter int BASE   = 0,
    parameter int DATA_W = 16,
    parameter int NAKW   = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  wr_ptr_i,
    input  logic [NAKW-1:0]   nak_limit_i,
    input  logic              in_token_i,
    input  logic              ack_i,
    input  logic              timeout_i,
    output logic [PTR_W-1:0]  rd_ptr_o,
    output logic              resp_nak_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_last_o
);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAXPKT);

    typedef struct packed {
        ep_state_e        st;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] len;
        logic             nak;
    } top_t;

    top_t top_d, top_q;

    logic [CNT_W-1:0] avail;
    logic             empty, full, release_ok;
    logic             start, bump, done;
    logic [CNT_W-1:0] start_len;
    logic [CNT_W-1:0] rd_sum;
    ep_answer_e       answer;

    in_ep_avail #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_avail (
        .wr_ptr_i (wr_ptr_i),
        .rd_ptr_i (top_q.rd),
        .avail_o  (avail),
        .empty_o  (empty),
        .full_o   (full)
    );

    in_ep_short_ctr #(.NAKW(NAKW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start | full),
        .bump_i    (bump),
        .full_i    (full),
        .limit_i   (nak_limit_i),
        .release_o (release_ok)
    );

    in_ep_word_reader #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE(BASE)) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_off_i (top_q.rd),
        .len_i       (start_len),
        .mem_rd_en_o (mem_rd_en_o),
        .mem_addr_o  (mem_addr_o),
        .done_o      (done),
        .tx_valid_o  (tx_valid_o),
        .tx_last_o   (tx_last_o)
    );

    always_comb begin
        top_d     = top_q;
        top_d.nak = 1'b0;
        start     = 1'b0;
        bump      = 1'b0;
        start_len = '0;
        answer    = pick_answer(empty, full, release_ok);
        rd_sum    = {1'b0, top_q.rd} + top_q.len;
        case (top_q.st)
            ST_IDLE: begin
                if (in_token_i) begin
                    case (answer)
                        ANS_FULL: begin
                            start     = 1'b1;
                            start_len = MAX_C;
                        end
                        ANS_SHORT: begin
                            start     = 1'b1;
                            start_len = avail;
                        end
                        ANS_NAK_HOLD: begin
                            top_d.nak = 1'b1;
                            bump      = 1'b1;
                        end
                        default: top_d.nak = 1'b1;
                    endcase
                    if (start) begin
                        top_d.len = start_len;
                        top_d.st  = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (done) top_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (ack_i) begin
                    top_d.rd = (rd_sum >= DEPTH_C) ? PTR_W'(rd_sum - DEPTH_C)
                                                   : PTR_W'(rd_sum);
                    top_d.st = ST_IDLE;
                end else if (timeout_i) begin
                    top_d.st = ST_IDLE;
                end
            end
            default: top_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '{st: ST_IDLE, rd: '0, len: '0, nak: 1'b0};
        else        top_q <= top_d;
    end

    assign rd_ptr_o   = top_q.rd;
    assign resp_nak_o = top_q.nak;
    assign tx_data_o  = mem_rdata_i;

    // R6
    rd_moves_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> $stable(rd_ptr_o));

    // R7
    timeout_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && !ack_i) |=> $stable(rd_ptr_o));

    // R8
    rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_o <= PTR_W'(DEPTH - 1));

    // R10
    busy_no_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.st != ST_IDLE) |=> !resp_nak_o);

    // R3
    nak_not_with_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_nak_o |-> !tx_valid_o && !mem_rd_en_o);

endmodule

// File: tb/in_ep_sched_bench.sv
module in_ep_sched_bench;
    localparam int DEPTH  = 12;
    localparam int MAXPKT = 4;
    localparam int ADDR_W = 8;
    localparam int BASE   = 'h40;
    localparam int PTR_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PTR_W-1:0]  wr_ptr = '0;
    logic [3:0]        nak_limit = '0;
    logic              in_token = 1'b0, ack = 1'b0, timeout = 1'b0;
    logic [PTR_W-1:0]  rd_ptr;
    logic              resp_nak, mem_rd_en, tx_valid, tx_last;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_rdata = '0, tx_data;

    logic [15:0] mem [256];
    int mwr = 0, mrd = 0, seq = 0;
    int checks = 0, fails = 0;
    int ngot = 0;
    logic [15:0] got [1024];
    logic        gotlast [1024];
    bit finished = 0;

    always #5 clk = ~clk;

    in_ep_sched #(.DEPTH(DEPTH), .MAXPKT(MAXPKT), .ADDR_W(ADDR_W), .BASE(BASE),
                  .DATA_W(16), .NAKW(4)) u_in_ep_sched (
        .clk(clk), .rst_n(rst_n), .wr_ptr_i(wr_ptr), .nak_limit_i(nak_limit),
        .in_token_i(in_token), .ack_i(ack), .timeout_i(timeout),
        .rd_ptr_o(rd_ptr), .resp_nak_o(resp_nak), .mem_rd_en_o(mem_rd_en),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid),
        .tx_data_o(tx_data), .tx_last_o(tx_last));

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    always @(negedge clk) begin
        if (tx_valid && ngot < 1024) begin
            got[ngot]     = tx_data;
            gotlast[ngot] = tx_last;
            ngot++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            mem[BASE + mwr] = 16'hA000 + 16'(seq);
            seq++;
            mwr = (mwr + 1) % DEPTH;
        end
        wr_ptr = PTR_W'(mwr);
    endtask

    task automatic pulse_token();
        @(negedge clk) in_token = 1'b1;
        @(negedge clk) in_token = 1'b0;
    endtask

    task automatic token_nak(input string req);
        pulse_token();
        chk(resp_nak == 1'b1, req, int'(resp_nak), 1);
    endtask

    task automatic token_pkt(input int len, input string req);
        int base;
        base = ngot;
        pulse_token();
        chk(resp_nak == 1'b0, req, int'(resp_nak), 0);
        repeat (len + 4) @(negedge clk);
        chk(ngot - base == len, req, ngot - base, len);
        for (int i = 0; i < len; i++) begin
            logic [15:0] e;
            e = mem[BASE + ((mrd + i) % DEPTH)];
            chk(got[base + i] == e, req, int'(got[base + i]), int'(e));
            chk(gotlast[base + i] == (i == len - 1), req,
                int'(gotlast[base + i]), int'(i == len - 1));
        end
    endtask

    task automatic do_ack(input int len, input string req);
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        mrd = (mrd + len) % DEPTH;
        chk(rd_ptr == PTR_W'(mrd), req, int'(rd_ptr), mrd);
    endtask

    task automatic t_reset();
        chk(rd_ptr == '0, "R1", int'(rd_ptr), 0);
        chk(!resp_nak && !mem_rd_en && !tx_valid, "R1",
            int'({resp_nak, mem_rd_en, tx_valid}), 0);
    endtask

    task automatic t_empty_and_short();
        nak_limit = 4'd1;
        token_nak("R3 empty");
        push(1);
        token_nak("R3 counter untouched by empty token");
        token_pkt(1, "R4 short after limit");
        do_ack(1, "R6 ack advances");
    endtask

    task automatic t_full();
        push(5);
        token_pkt(MAXPKT, "R2 full packet");
        chk(rd_ptr == PTR_W'(mrd), "R6 no move before ack", int'(rd_ptr), mrd);
        do_ack(MAXPKT, "R6 ack full");
    endtask

    task automatic t_timeout();
        nak_limit = 4'd0;
        token_pkt(1, "R5 limit zero");
        @(negedge clk) timeout = 1'b1;
        @(negedge clk) timeout = 1'b0;
        chk(rd_ptr == PTR_W'(mrd), "R7 timeout keeps offset", int'(rd_ptr), mrd);
        token_pkt(1, "R7 resend");
        do_ack(1, "R7 ack after resend");
    endtask

    task automatic t_wrap();
        push(8);
        token_pkt(MAXPKT, "R8 first");
        do_ack(MAXPKT, "R8 first ack");
        token_pkt(MAXPKT, "R8 packet crosses ring end");
        do_ack(MAXPKT, "R8 offset wraps");
    endtask

    task automatic t_clear();
        nak_limit = 4'd3;
        push(1);
        token_nak("R4 hold 1");
        token_nak("R4 hold 2");
        push(3);
        token_pkt(MAXPKT, "R9 full send");
        do_ack(MAXPKT, "R9 ack");
        push(1);
        token_nak("R9 cleared nak 1");
        token_nak("R9 cleared nak 2");
        token_nak("R9 cleared nak 3");
        token_pkt(1, "R9 short after three");
        do_ack(1, "R9 short ack");
    endtask

    task automatic t_ignore();
        int base;
        nak_limit = 4'd0;
        push(4);
        base = ngot;
        pulse_token();
        chk(resp_nak == 1'b0, "R10 first token", int'(resp_nak), 0);
        pulse_token();
        chk(resp_nak == 1'b0, "R10 token while sending", int'(resp_nak), 0);
        repeat (6) @(negedge clk);
        pulse_token();
        chk(resp_nak == 1'b0, "R10 token while waiting", int'(resp_nak), 0);
        repeat (6) @(negedge clk);
        chk(ngot - base == MAXPKT, "R10 single packet", ngot - base, MAXPKT);
        chk(got[base] == mem[BASE + mrd], "R11 first word", int'(got[base]),
            int'(mem[BASE + mrd]));
        do_ack(MAXPKT, "R10 ack");
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        chk(rd_ptr == PTR_W'(mrd), "R10 idle ack ignored", int'(rd_ptr), mrd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_and_short();
        t_full();
        t_timeout();
        t_wrap();
        t_clear();
        t_ignore();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule